// File: doc/BRIEF.md
# Frame Counter and List Pointer

This block keeps the frame timing state of a host controller schedule engine. An 11-bit frame counter steps once for each end-of-frame strobe while the controller runs. Its value is the number placed into each start-of-frame packet. A second register holds the 4 KB-aligned base of a 1024-entry frame list in memory. The block joins that base with the low ten counter bits to form the dword address of the list entry for the current frame. The fetch logic reads that address directly.

Software reaches both registers through a simple write/read port with byte enables. The frame counter is protected from writes. It takes a new value only from a full 16-bit write made while the controller reports halted and run/stop is clear. Every other attempt is dropped.

Top module: `frm_sched_timer`

## Requirements
- R1: After a synchronous reset, `sof_frame` is 000h and a read of the frame register (`rd_addr`=0) returns 00000000h.
- R2: A read of the frame register returns the counter in bits 10:0 and zero in bits 31:11. Read data appears on `rd_data` one cycle after `rd_en`.
- R3: When `eof_strobe` is high, `run_stop` is high and `halted` is low, the counter increases by one at that clock edge.
- R4: The counter wraps from 7FFh to 000h, so the list index (bits 9:0) wraps from 3FFh to 000h.
- R5: An end-of-frame strobe does not change the counter while `run_stop` is low or `halted` is high.
- R6: `sof_frame` always equals the value the frame register reads back.
- R7: A write to the frame register (`wr_addr`=0) with `wr_be[1:0]`=11b, `halted` high and `run_stop` low loads `wr_data[10:0]` into the counter.
- R8: A frame register write is ignored whenever `run_stop` is high.
- R9: A frame register write is ignored whenever `halted` is low.
- R10: A frame register write with only one of `wr_be[1:0]` set is ignored.
- R11: A write to the base register (`wr_addr`=1) stores only bits 31:12, byte by byte under `wr_be[3:1]`. Base reads return zero in bits 11:0. Base writes are not gated by run/stop.
- R12: `list_ptr` equals the stored base in bits 31:12, counter bits 9:0 in bits 11:2, and 00b in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_stop | input | 1 | Controller run command |
| halted | input | 1 | Controller halted status |
| eof_strobe | input | 1 | One-cycle end-of-frame pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 frame, 1 base |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Write byte enables |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | Read register select: 0 frame, 1 base |
| rd_data | output | 32 | Registered read data |
| sof_frame | output | 11 | Current frame number for start-of-frame packets |
| list_ptr | output | 32 | Address of the current frame list entry |

## Verification
A corrupted counter shows on `sof_frame` and in the middle bits of `list_ptr` at the edge that corrupts it. A read of the frame register shows it one cycle later. An increment that should have happened, or a stray increment, appears right after the strobe edge. A write that slips past the gate appears on the next edge. Base storage that keeps low bits, or that writes unselected bytes, shows in the next base read and in the upper bits of `list_ptr`.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic {
    SEL_FRAME = 1'b0,
    SEL_BASE  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/frm_wr_gate.sv
module frm_wr_gate
  import frm_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int FN_W  = 11
) (
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [REG_W/8-1:0] wr_be,
  input  logic               run_stop,
  input  logic               halted,
  output logic               frame_load,
  output logic [FN_W-1:0]    frame_val,
  output logic               base_we,
  output logic [REG_W/8-1:0] base_be,
  output logic [REG_W-1:0]   base_data
);
  logic sel_frame;
  logic full_word;

  always_comb begin
    sel_frame  = (reg_sel_e'(wr_addr) == SEL_FRAME);
    full_word  = (wr_be[1:0] == 2'b11);
    frame_load = wr_en && sel_frame && full_word && halted && !run_stop;
    frame_val  = wr_data[FN_W-1:0];
    base_we    = wr_en && !sel_frame;
    base_be    = wr_be;
    base_data  = wr_data;
  end
endmodule

// File: rtl/frm_counter.sv
module frm_counter #(
  parameter int FN_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [FN_W-1:0] load_val,
  input  logic            inc,
  output logic [FN_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (inc)  count <= count + 1'b1;
  end

  p_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (count == FN_W'($past(count) + 1'b1)));
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && (&count)) |=> (count == '0));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(count));
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val)));
endmodule

// File: rtl/frm_base_reg.sv
module frm_base_reg #(
  parameter int REG_W      = 32,
  parameter int ALIGN_BITS = 12
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [REG_W/8-1:0]    be,
  input  logic [REG_W-1:0]      wd,
  output logic [REG_W-1:ALIGN_BITS] base
);
  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = ALIGN_BITS; i < REG_W; i++) begin
        if (be[i/8]) base[i] <= wd[i];
      end
    end
  end
endmodule

// File: rtl/frm_sched_timer.sv
module frm_sched_timer
  import frm_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter int FN_W        = 11,
  parameter int ALIGN_BITS  = 12,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_stop,
  input  logic             halted,
  input  logic             eof_strobe,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [3:0]       wr_be,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [31:0]      rd_data,
  output logic [10:0]      sof_frame,
  output logic [31:0]      list_ptr
);
  localparam int IDX_W = ALIGN_BITS - ENTRY_SHIFT;
  localparam int BE_W  = REG_W / 8;

  logic                      frame_load;
  logic [FN_W-1:0]           frame_val;
  logic                      base_we;
  logic [BE_W-1:0]           base_be;
  logic [REG_W-1:0]          base_data;
  logic [FN_W-1:0]           frame_q;
  logic [REG_W-1:ALIGN_BITS] base_q;
  logic                      frame_inc;

  frm_wr_gate #(.REG_W(REG_W), .FN_W(FN_W)) u_gate (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .run_stop(run_stop), .halted(halted),
    .frame_load(frame_load), .frame_val(frame_val),
    .base_we(base_we), .base_be(base_be), .base_data(base_data)
  );

  assign frame_inc = eof_strobe && run_stop && !halted;

  frm_counter #(.FN_W(FN_W)) u_cnt (
    .clk(clk), .rst(rst), .load(frame_load), .load_val(frame_val),
    .inc(frame_inc), .count(frame_q)
  );

  frm_base_reg #(.REG_W(REG_W), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .clk(clk), .we(base_we), .be(base_be), .wd(base_data), .base(base_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      if (reg_sel_e'(rd_addr) == SEL_BASE) rd_data <= {base_q, {ALIGN_BITS{1'b0}}};
      else                                 rd_data <= {{(REG_W-FN_W){1'b0}}, frame_q};
    end
  end

  assign sof_frame = frame_q;
  assign list_ptr  = {base_q, frame_q[IDX_W-1:0], {ENTRY_SHIFT{1'b0}}};

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == 1'b0) |=> (rd_data[31:FN_W] == '0));
  p_readback_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == 1'b0) |=> (rd_data[FN_W-1:0] == $past(sof_frame)));
  p_run_block_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 1'b0 && run_stop && !eof_strobe) |=> $stable(sof_frame));
  p_live_block_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 1'b0 && !halted && !eof_strobe) |=> $stable(sof_frame));
  p_partial_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 1'b0 && wr_be[1:0] != 2'b11 && !eof_strobe) |=> $stable(sof_frame));
  p_base_low_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == 1'b1) |=> (rd_data[ALIGN_BITS-1:0] == '0));
  p_ptr_align_r12: assert property (@(posedge clk) disable iff (rst)
    list_ptr[ENTRY_SHIFT-1:0] == '0);
endmodule

// File: tb/tb_frm_sched_timer.sv
module tb_frm_sched_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_stop = 1'b0, halted = 1'b1, eof_strobe = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_en = 1'b0, rd_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] rd_data, list_ptr;
  logic [10:0] sof_frame;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frm_sched_timer dut (
    .clk(clk), .rst(rst), .run_stop(run_stop), .halted(halted),
    .eof_strobe(eof_strobe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .sof_frame(sof_frame), .list_ptr(list_ptr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic eof_pulse();
    @(negedge clk);
    eof_strobe = 1'b1;
    @(negedge clk);
    eof_strobe = 1'b0;
  endtask

  task automatic set_ctl(logic rs, logic h);
    @(negedge clk);
    run_stop = rs; halted = h;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 sof_frame", {21'b0, sof_frame}, 32'h0);
    rd(1'b0, d);
    check("R1 frame read", d, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] d;
    set_ctl(1'b0, 1'b1);
    wr(1'b0, 32'h0000_1234, 4'b0011);
    check("R7 load", {21'b0, sof_frame}, 32'h234);
    rd(1'b0, d);
    check("R6 readback", d, 32'h234);
    wr(1'b0, 32'hFFFF_FFFF, 4'b1111);
    rd(1'b0, d);
    check("R2 reserved bits zero", d, 32'h7FF);
  endtask

  task automatic t_blocked();
    wr(1'b0, 32'h0000_0010, 4'b0011);
    set_ctl(1'b1, 1'b0);
    wr(1'b0, 32'h0000_0100, 4'b0011);
    check("R8 write while running", {21'b0, sof_frame}, 32'h010);
    set_ctl(1'b1, 1'b1);
    wr(1'b0, 32'h0000_0101, 4'b0011);
    check("R8 write running and halted", {21'b0, sof_frame}, 32'h010);
    set_ctl(1'b0, 1'b0);
    wr(1'b0, 32'h0000_0102, 4'b0011);
    check("R9 write not halted", {21'b0, sof_frame}, 32'h010);
    set_ctl(1'b0, 1'b1);
    wr(1'b0, 32'h0000_0103, 4'b0001);
    check("R10 low byte only", {21'b0, sof_frame}, 32'h010);
    wr(1'b0, 32'h0000_0304, 4'b0010);
    check("R10 high byte only", {21'b0, sof_frame}, 32'h010);
  endtask

  task automatic t_count();
    logic [31:0] d;
    set_ctl(1'b0, 1'b1);
    wr(1'b0, 32'h0000_0005, 4'b0011);
    set_ctl(1'b1, 1'b0);
    for (int k = 0; k < 3; k++) eof_pulse();
    check("R3 three increments", {21'b0, sof_frame}, 32'h008);
    rd(1'b0, d);
    check("R6 count readback", d, 32'h008);
    set_ctl(1'b0, 1'b1);
    eof_pulse();
    check("R5 halted no increment", {21'b0, sof_frame}, 32'h008);
    set_ctl(1'b1, 1'b1);
    eof_pulse();
    check("R5 run and halted no increment", {21'b0, sof_frame}, 32'h008);
    set_ctl(1'b0, 1'b0);
    eof_pulse();
    check("R5 stopped no increment", {21'b0, sof_frame}, 32'h008);
  endtask

  task automatic t_base_ptr();
    logic [31:0] d;
    set_ctl(1'b1, 1'b0);
    wr(1'b1, 32'hABCD_EFFF, 4'b1111);
    rd(1'b1, d);
    check("R11 base low bits zero", d, 32'hABCD_E000);
    wr(1'b1, 32'h1200_0000, 4'b1000);
    rd(1'b1, d);
    check("R11 top byte only", d, 32'h12CD_E000);
    wr(1'b1, 32'h0000_5A00, 4'b0010);
    rd(1'b1, d);
    check("R11 byte1 upper nibble", d, 32'h12CD_5000);
    set_ctl(1'b0, 1'b1);
    wr(1'b0, 32'h0000_07FE, 4'b0011);
    check("R12 pointer", list_ptr, 32'h12CD_5FF8);
    set_ctl(1'b1, 1'b0);
    eof_pulse();
    check("R12 pointer top index", list_ptr, 32'h12CD_5FFC);
    eof_pulse();
    check("R4 wrap to zero", {21'b0, sof_frame}, 32'h000);
    check("R4 index wrap in pointer", list_ptr, 32'h12CD_5000);
    set_ctl(1'b0, 1'b1);
    wr(1'b0, 32'h0000_03FF, 4'b0011);
    set_ctl(1'b1, 1'b0);
    eof_pulse();
    check("R12 bit10 not in pointer", list_ptr, 32'h12CD_5000);
    check("R3 carry into bit10", {21'b0, sof_frame}, 32'h400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_blocked();
    t_count();
    t_base_ptr();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule